// File: doc/BRIEF.md
# Ternary-Match Floating-Point Result Memoization Unit

This block sits next to a floating-point unit and short-circuits computations whose results are already known. Host software fills a small table before a kernel starts. Each entry holds the following:

- an opcode tag;
- a value word and a care mask for each of two operands;
- a 32-bit result;
- a valid bit.

While the kernel runs, every issued operation is looked up against all entries in parallel. Masked operand bits match anything, so one entry can cover a family of nearby operand values.

The lookup is a two-stage pipeline. Stage one compares the opcode and operands against every entry and registers the match vector. Stage two picks the lowest-numbered matching entry and reads its stored result. At the stage-two output, the unit presents the final result aligned with the FPU result for the same operation. The unit returns the stored result on a hit and the FPU result on a miss. A hit marks the operation as needing no recovery, even if the FPU result was faulty.

Writes through the programming port are held off by a busy signal while any lookup is in flight. Two running counters, one for lookups and one for hits, let software compute the hit rate. A clear strobe resets both counters.

Top module: `fpu_memo_unit`

## Requirements
- R1: After reset, every entry is invalid. `out_valid` and `wr_busy` are low, both counters read zero, and a lookup misses and returns the FPU result.
- R2: A lookup presented with `lu_valid` high at clock edge t gives `out_valid` high, with its hit flag and result, in the cycle following edge t+1. This is the same cycle in which the FPU result for that operation is presented on `fpu_result`.
- R3: An operand matches an entry when every bit whose mask bit is 0 equals the stored value bit. Bits whose mask bit is 1 are don't-care.
- R4: An entry hits only when its opcode tag equals the lookup opcode. The encodings are 0 add, 1 multiply, 2 square root and 3 multiply-add.
- R5: For square root (opcode 2), operand b plays no part in the match.
- R6: When several entries match, the one with the lowest index supplies the result.
- R7: On a hit, `out_hit` is 1 and `out_result` is the stored result, whatever `fpu_result` holds. On a miss, `out_hit` is 0 and `out_result` equals `fpu_result`.
- R8: `wr_busy` is high whenever `lu_valid` is high or a lookup occupies either stage. A write is applied only at an edge where `wr_en` is high and `wr_busy` is low. A lookup in flight therefore sees the old contents.
- R9: `lookup_count` increments once for each lookup result and `hit_count` once for each hit. A cycle with `clr_stats` high sets both to zero at the next edge.
- R10: An entry written with `wr_entry_valid` 0 never hits, even if its fields would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Programming write request, held until accepted |
| wr_idx | input | 5 | Entry index to write |
| wr_entry_valid | input | 1 | Valid bit to store for the entry |
| wr_op | input | 2 | Opcode tag for the entry |
| wr_a_val | input | 32 | Operand a value word |
| wr_a_msk | input | 32 | Operand a don't-care mask (1 = ignore bit) |
| wr_b_val | input | 32 | Operand b value word |
| wr_b_msk | input | 32 | Operand b don't-care mask (1 = ignore bit) |
| wr_result | input | 32 | Stored result for the entry |
| wr_busy | output | 1 | Write is stalled while lookups are in flight |
| clr_stats | input | 1 | Clears both counters |
| lu_valid | input | 1 | Lookup issue strobe |
| lu_op | input | 2 | Lookup opcode |
| lu_a | input | 32 | Lookup operand a |
| lu_b | input | 32 | Lookup operand b |
| fpu_result | input | 32 | FPU result, presented in the same cycle as `out_valid` |
| out_valid | output | 1 | Lookup result available |
| out_hit | output | 1 | Lookup hit; no recovery needed |
| out_result | output | 32 | Selected result |
| lookup_count | output | 32 | Running lookup count |
| hit_count | output | 32 | Running hit count |

## Verification
Every lookup result is due one cycle after the edge that follows the issuing edge. The bench models the FPU as a two-register delay line, so its value arrives in that same cycle.

A driver task pushes the expected hit flag and result into a queue at issue time. A monitor pops an entry on each cycle with `out_valid` high, sampling on the falling clock edge. Because of this, neither an early result nor a late one can pass, and a result with an empty queue is a failure.

`wr_busy` is sampled one time unit after inputs change, so its value reflects the cycle in which it is read. The counters and their clear take effect at the next edge and are read on the falling edge after it.

// File: rtl/fpu_memo_pkg.sv
// Shared types for the memoization unit.
// Assumes: two operands of equal width and a 2-bit opcode space.
package fpu_memo_pkg;
    typedef enum logic [1:0] {
        MOP_ADD  = 2'd0,
        MOP_MUL  = 2'd1,
        MOP_SQRT = 2'd2,
        MOP_FMA  = 2'd3
    } memo_op_e;
endpackage

// File: rtl/fpu_memo_table.sv
// Ternary search stage (stage one) of the memoization unit.
// It holds the opcode tags, operand value/mask words and valid bits.
// A search compares all entries in parallel and registers the match vector.
// Assumes: writes (we) only arrive while no search is in flight.
module fpu_memo_table
    import fpu_memo_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     w_idx,
    input  logic                 w_vld,
    input  memo_op_e             w_op,
    input  logic [DATA_W-1:0]    w_a_val,
    input  logic [DATA_W-1:0]    w_a_msk,
    input  logic [DATA_W-1:0]    w_b_val,
    input  logic [DATA_W-1:0]    w_b_msk,
    input  logic                 srch,
    input  memo_op_e             s_op,
    input  logic [DATA_W-1:0]    s_a,
    input  logic [DATA_W-1:0]    s_b,
    output logic                 s1_vld,
    output logic [N_ENTRIES-1:0] s1_match
);
    logic [N_ENTRIES-1:0] vld_q;
    memo_op_e             op_q  [N_ENTRIES];
    logic [DATA_W-1:0]    av_q  [N_ENTRIES];
    logic [DATA_W-1:0]    am_q  [N_ENTRIES];
    logic [DATA_W-1:0]    bv_q  [N_ENTRIES];
    logic [DATA_W-1:0]    bm_q  [N_ENTRIES];
    logic [N_ENTRIES-1:0] hit_c;

    // Valid bits: cleared by reset, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  vld_q <= '0;
        else if (we) vld_q[w_idx] <= w_vld;
    end

    // Pattern fields: no reset needed, they are guarded by the valid bits.
    always_ff @(posedge clk) begin
        if (we) begin
            op_q[w_idx] <= w_op;
            av_q[w_idx] <= w_a_val;
            am_q[w_idx] <= w_a_msk;
            bv_q[w_idx] <= w_b_val;
            bm_q[w_idx] <= w_b_msk;
        end
    end

    // One ternary comparator per entry.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        logic a_ok, b_ok;
        // Operand a and b matches; square root ignores operand b.
        always_comb begin
            a_ok = &(am_q[g] | ~(av_q[g] ^ s_a));
            b_ok = (op_q[g] == MOP_SQRT) || (&(bm_q[g] | ~(bv_q[g] ^ s_b)));
            hit_c[g] = vld_q[g] && (op_q[g] == s_op) && a_ok && b_ok;
        end
    end

    // Stage-one register: the match vector is zero when no search was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_match <= '0;
        end else begin
            s1_vld   <= srch;
            s1_match <= srch ? hit_c : '0;
        end
    end

    // R10
    only_valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_match & ~vld_q) == '0);
endmodule

// File: rtl/fpu_memo_prio.sv
// Fixed-priority selector: the lowest set bit of the match vector wins.
// It is purely combinational; the clock and reset only serve the checks.
module fpu_memo_prio #(
    parameter int N_ENTRIES = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] match,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the top down so that the lowest matching index is kept last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R6
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (match[idx] && ((match & ((N_ENTRIES'(1) << idx) - N_ENTRIES'(1))) == '0)));
endmodule

// File: rtl/fpu_memo_resmem.sv
// Result memory and stage-two register of the memoization unit.
// It reads the stored result of the selected entry and registers the hit flag.
// Assumes: writes only arrive while the pipeline is idle.
module fpu_memo_resmem #(
    parameter int N_ENTRIES = 32,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_res,
    input  logic              rd_vld,
    input  logic              rd_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              s2_vld,
    output logic              s2_hit,
    output logic [DATA_W-1:0] s2_res
);
    logic [DATA_W-1:0] mem_q [N_ENTRIES];

    // Result storage write port.
    always_ff @(posedge clk) begin
        if (we) mem_q[w_idx] <= w_res;
    end

    // Stage-two register: valid, hit and stored result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_hit <= 1'b0;
            s2_res <= '0;
        end else begin
            s2_vld <= rd_vld;
            s2_hit <= rd_vld && rd_hit;
            s2_res <= mem_q[rd_idx];
        end
    end

    // R7
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_hit |-> s2_vld);
endmodule

// File: rtl/fpu_memo_unit.sv
// Top of the memoization unit: write gating, two-stage lookup, output
// selection against the FPU result, and hit/lookup counters.
// Assumes: fpu_result for an operation is presented in the cycle where
// out_valid goes high for it; wr_en is held until wr_busy is low.
module fpu_memo_unit
    import fpu_memo_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_entry_valid,
    input  logic [1:0]        wr_op,
    input  logic [DATA_W-1:0] wr_a_val,
    input  logic [DATA_W-1:0] wr_a_msk,
    input  logic [DATA_W-1:0] wr_b_val,
    input  logic [DATA_W-1:0] wr_b_msk,
    input  logic [DATA_W-1:0] wr_result,
    output logic              wr_busy,
    input  logic              clr_stats,
    input  logic              lu_valid,
    input  logic [1:0]        lu_op,
    input  logic [DATA_W-1:0] lu_a,
    input  logic [DATA_W-1:0] lu_b,
    input  logic [DATA_W-1:0] fpu_result,
    output logic              out_valid,
    output logic              out_hit,
    output logic [DATA_W-1:0] out_result,
    output logic [CNT_W-1:0]  lookup_count,
    output logic [CNT_W-1:0]  hit_count
);
    logic                 we;
    logic                 s1_vld;
    logic [N_ENTRIES-1:0] s1_match;
    logic                 sel_any;
    logic [IDX_W-1:0]     sel_idx;
    logic [DATA_W-1:0]    memo_res;

    // A write is applied only when nothing is issued or in flight.
    always_comb begin
        wr_busy = lu_valid || s1_vld || out_valid;
        we      = wr_en && !wr_busy;
    end

    fpu_memo_table #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .w_idx    (wr_idx),
        .w_vld    (wr_entry_valid),
        .w_op     (memo_op_e'(wr_op)),
        .w_a_val  (wr_a_val),
        .w_a_msk  (wr_a_msk),
        .w_b_val  (wr_b_val),
        .w_b_msk  (wr_b_msk),
        .srch     (lu_valid),
        .s_op     (memo_op_e'(lu_op)),
        .s_a      (lu_a),
        .s_b      (lu_b),
        .s1_vld   (s1_vld),
        .s1_match (s1_match)
    );

    fpu_memo_prio #(.N_ENTRIES(N_ENTRIES)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .match (s1_match),
        .any   (sel_any),
        .idx   (sel_idx)
    );

    fpu_memo_resmem #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_resmem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .w_idx  (wr_idx),
        .w_res  (wr_result),
        .rd_vld (s1_vld),
        .rd_hit (sel_any),
        .rd_idx (sel_idx),
        .s2_vld (out_valid),
        .s2_hit (out_hit),
        .s2_res (memo_res)
    );

    // Output selection: the stored result overrides the FPU on a hit.
    always_comb out_result = out_hit ? memo_res : fpu_result;

    // Statistics counters; the clear strobe takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_stats) begin
            lookup_count <= '0;
            hit_count    <= '0;
        end else if (out_valid) begin
            lookup_count <= lookup_count + CNT_W'(1);
            hit_count    <= hit_count + CNT_W'(out_hit);
        end
    end

    // R2
    two_stage_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lu_valid, 2));

    // R8
    busy_while_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(wr_busy));

    // R9
    hits_within_lookups_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= lookup_count);
endmodule

// File: tb/fpu_memo_unit_tb.sv
// Scoreboard bench for fpu_memo_unit.
module fpu_memo_unit_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic          wr_entry_valid = 1'b0;
    logic [1:0]    wr_op = '0;
    logic [DW-1:0] wr_a_val = '0, wr_a_msk = '0, wr_b_val = '0, wr_b_msk = '0, wr_result = '0;
    logic          wr_busy;
    logic          clr_stats = 1'b0;
    logic          lu_valid = 1'b0;
    logic [1:0]    lu_op = '0;
    logic [DW-1:0] lu_a = '0, lu_b = '0;
    logic [DW-1:0] tb_fpu = '0, fpu_d1 = '0, fpu_result = '0;
    logic          out_valid, out_hit;
    logic [DW-1:0] out_result;
    logic [31:0]   lookup_count, hit_count;

    int n_chk = 0;
    int n_fail = 0;
    int exp_lu = 0;
    int exp_hits = 0;
    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    fpu_memo_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_entry_valid(wr_entry_valid), .wr_op(wr_op),
        .wr_a_val(wr_a_val), .wr_a_msk(wr_a_msk), .wr_b_val(wr_b_val),
        .wr_b_msk(wr_b_msk), .wr_result(wr_result), .wr_busy(wr_busy),
        .clr_stats(clr_stats), .lu_valid(lu_valid), .lu_op(lu_op),
        .lu_a(lu_a), .lu_b(lu_b), .fpu_result(fpu_result),
        .out_valid(out_valid), .out_hit(out_hit), .out_result(out_result),
        .lookup_count(lookup_count), .hit_count(hit_count)
    );

    // Model of the FPU: its result arrives two edges after issue.
    always @(posedge clk) begin
        fpu_d1     <= tb_fpu;
        fpu_result <= fpu_d1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item for each result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected result", {31'b0, out_hit, out_result}, 64'h0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_hit, out_result} === e, t, {31'b0, out_hit, out_result}, {31'b0, e});
            end
        end
    end

    // Driver: issue one lookup and push its expected outcome.
    task automatic lookup(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [DW-1:0] fpu, input bit hit, input logic [DW-1:0] res,
                          input string req);
        exp_q.push_back({hit, hit ? res : fpu});
        tag_q.push_back(req);
        exp_lu++;
        if (hit) exp_hits++;
        lu_valid = 1'b1; lu_op = op; lu_a = a; lu_b = b; tb_fpu = fpu;
        @(negedge clk);
        lu_valid = 1'b0;
    endtask

    task automatic set_wr(input int idx, input bit v, input logic [1:0] op,
                          input logic [DW-1:0] av, input logic [DW-1:0] am,
                          input logic [DW-1:0] bv, input logic [DW-1:0] bm,
                          input logic [DW-1:0] res);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_entry_valid = v; wr_op = op;
        wr_a_val = av; wr_a_msk = am; wr_b_val = bv; wr_b_msk = bm; wr_result = res;
    endtask

    // Hold the write until an edge with wr_busy low accepts it.
    task automatic wait_wr();
        forever begin
            #1;
            if (!wr_busy) begin
                @(negedge clk);
                wr_en = 1'b0;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic prog(input int idx, input bit v, input logic [1:0] op,
                        input logic [DW-1:0] av, input logic [DW-1:0] am,
                        input logic [DW-1:0] bv, input logic [DW-1:0] bm,
                        input logic [DW-1:0] res);
        set_wr(idx, v, op, av, am, bv, bm, res);
        wait_wr();
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'h0, 64'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", {63'b0, out_valid}, 64'h0);
        chk(wr_busy == 1'b0, "R1 wr_busy", {63'b0, wr_busy}, 64'h0);
        chk(lookup_count == 0 && hit_count == 0, "R1 counters", {lookup_count, hit_count}, 64'h0);
        @(negedge clk);
        lookup(2'd0, 32'h3F800000, 32'h40000000, 32'hAAAA0001, 1'b0, 32'h0, "R1 empty table miss");
        drain();

        // Program: opcode 0 add, 1 multiply, 2 square root, 3 multiply-add.
        prog(0, 1, 2'd0, 32'h3F800000, 32'h0000FFFF, 32'h40000000, 32'h0, 32'h40400000);
        prog(2, 1, 2'd2, 32'h40800000, 32'h0, 32'h12345678, 32'h0, 32'h40000000);
        prog(5, 1, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h41200000, 32'h0, 32'h11111111);
        prog(9, 1, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h41200000, 32'h0, 32'h22222222);
        prog(12, 1, 2'd3, 32'h40A00000, 32'h0, 32'h40C00000, 32'h0, 32'h41F00000);

        // R3: masked low bits ignored, unmasked bit 16 differs -> miss
        lookup(2'd0, 32'h3F801234, 32'h40000000, 32'hBEEF0001, 1'b1, 32'h40400000, "R3 masked hit");
        lookup(2'd0, 32'h3F811234, 32'h40000000, 32'hBEEF0002, 1'b0, 32'h0, "R3 unmasked miss");
        lookup(2'd0, 32'h3F800000, 32'h40000001, 32'hBEEF0003, 1'b0, 32'h0, "R3 operand b miss");
        // R4: same operands, other opcode
        lookup(2'd1, 32'h3F800000, 32'h40000000, 32'hBEEF0004, 1'b0, 32'h0, "R4 opcode mismatch");
        lookup(2'd3, 32'h40A00000, 32'h40C00000, 32'hBEEF0005, 1'b1, 32'h41F00000, "R4 multiply-add hit");
        // R5: square root ignores b
        lookup(2'd2, 32'h40800000, 32'hDEADBEEF, 32'hBEEF0006, 1'b1, 32'h40000000, "R5 sqrt ignores b");
        // R6: entries 5 and 9 both match
        lookup(2'd1, 32'h7777AAAA, 32'h41200000, 32'hBEEF0007, 1'b1, 32'h11111111, "R6 lowest index wins");
        // R7: FPU value on miss, stored value on hit (back to back)
        lookup(2'd1, 32'h1, 32'h41200001, 32'hCAFE0008, 1'b0, 32'h0, "R7 miss passes FPU");
        lookup(2'd2, 32'h40800000, 32'h0, 32'hCAFE0009, 1'b1, 32'h40000000, "R7 hit overrides FPU");
        drain();

        // R10: invalidate entry 5, entry 9 now wins
        prog(5, 0, 2'd1, 32'h0, 32'hFFFFFFFF, 32'h41200000, 32'h0, 32'h11111111);
        lookup(2'd1, 32'h7777AAAA, 32'h41200000, 32'hBEEF000A, 1'b1, 32'h22222222, "R10 invalid entry skipped");
        drain();

        // R8: write requested together with a lookup must wait
        set_wr(2, 1, 2'd2, 32'h40800000, 32'h0, 32'h0, 32'h0, 32'h55555555);
        exp_q.push_back({1'b1, 32'h40000000});
        tag_q.push_back("R8 in-flight sees old contents");
        exp_lu++; exp_hits++;
        lu_valid = 1'b1; lu_op = 2'd2; lu_a = 32'h40800000; lu_b = 32'h0; tb_fpu = 32'hBEEF000B;
        #1;
        chk(wr_busy == 1'b1, "R8 busy with lookup", {63'b0, wr_busy}, 64'h1);
        @(negedge clk);
        lu_valid = 1'b0;
        #1;
        chk(wr_busy == 1'b1, "R8 busy in flight", {63'b0, wr_busy}, 64'h1);
        wait_wr();
        lookup(2'd2, 32'h40800000, 32'h0, 32'hBEEF000C, 1'b1, 32'h55555555, "R8 write applied after idle");
        drain();

        // R9: counters then clear
        chk(lookup_count == 32'(exp_lu), "R9 lookup count", {32'b0, lookup_count}, 64'(exp_lu));
        chk(hit_count == 32'(exp_hits), "R9 hit count", {32'b0, hit_count}, 64'(exp_hits));
        clr_stats = 1'b1;
        @(negedge clk);
        clr_stats = 1'b0;
        chk(lookup_count == 0 && hit_count == 0, "R9 clear", {lookup_count, hit_count}, 64'h0);
        exp_lu = 0; exp_hits = 0;
        lookup(2'd1, 32'h5, 32'h41200000, 32'h1, 1'b1, 32'h22222222, "R9 post-clear hit");
        lookup(2'd0, 32'h5, 32'h5, 32'h2, 1'b0, 32'h0, "R9 post-clear miss");
        drain();
        chk(lookup_count == 32'd2 && hit_count == 32'd1, "R9 recount",
            {lookup_count, hit_count}, {32'd2, 32'd1});
        chk(exp_q.size() == 0, "R2 all results returned", 64'(exp_q.size()), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule